// File: doc/BRIEF.md
# Byte Multiply-Divide Unit

This block is the sequential arithmetic unit that a small 8-bit processor core uses for its byte multiply and byte divide instructions. The core presents the two unsigned operands it holds in its accumulator and its B register, selects multiply or divide, and pulses a start input. The unit then runs for a fixed latency. It uses shift-and-add steps for multiply and restoring shift-and-subtract steps for divide. At the end it presents two result bytes, destined for A and B, together with the carry and overflow flags. A one-clock done pulse tells the core that it may write them.

The latency is a whole number of machine cycles, and each machine cycle is a fixed number of clocks. With the default parameters the operation takes 4 machine cycles of 4 clocks, so 16 clocks. The iterations fill the first 8 of those clocks. The unit then waits in a settle state until the full latency has passed, so the instruction timing stays the same whatever the operands are.

The controller has three states. IDLE accepts a start pulse and moves to ITERATE. ITERATE runs one shift step per clock and moves to SETTLE once the last step is done. SETTLE waits out the rest of the latency, then commits the results, pulses done and returns to IDLE.

Top module: `byte_muldiv_unit`

## Requirements
- R1: After reset, busy_o, done_o, acc_o, b_o, cy_o and ov_o are all 0.
- R2: With op_div_i = 0 (multiply), the unsigned product of acc_i and b_i is presented with its low byte on acc_o and its high byte on b_o.
- R3: After a multiply, ov_o is 1 exactly when the product is greater than 255.
- R4: After every multiply and every divide, cy_o is 0.
- R5: With op_div_i = 1 (divide) and a nonzero b_i, acc_o carries the unsigned quotient acc_i / b_i, b_o carries the remainder, and ov_o is 0.
- R6: A divide whose b_i is 0 sets ov_o to 1 and returns the operands unchanged: acc_o equals acc_i and b_o is 0.
- R7: The start pulse is sampled on a rising clock edge. busy_o is 1 from that edge until the edge 16 clocks later. At that later edge busy_o falls, the results and flags change, and done_o goes high for exactly one clock.
- R8: A start pulse that arrives while busy_o is 1 is ignored. The running operation finishes at its own time with its own operands, and no extra operation follows it.
- R9: acc_o, b_o, cy_o and ov_o change only on the edge that raises done_o, and hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on a rising edge while idle |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| acc_i | input | 8 | Accumulator operand |
| b_i | input | 8 | B register operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-clock pulse when the results are written |
| acc_o | output | 8 | Result for A: product low byte or quotient |
| b_o | output | 8 | Result for B: product high byte or remainder |
| cy_o | output | 1 | Carry flag result |
| ov_o | output | 1 | Overflow flag result |

## Verification
A wrong step counter or a wrong state transition in the controller moves the done pulse away from its fixed position 16 clocks after start. It can also leave busy_o high or raise a second pulse, and all of this is visible within one operation. A fault in the shared shift register shows only at the commit edge, as a wrong byte on acc_o or b_o. For that reason operand pairs are chosen to reach the top product bit, exact 255 and 256 products, a quotient of 255, a divisor larger than the dividend, and divisor zero. A swept grid of operands covers both operations. A flag or hold fault shows as a change on a result port in a cycle where done_o is low.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ITERATE = 2'd1,
        ST_SETTLE  = 2'd2
    } seq_state_t;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } muldiv_op_t;

endpackage

// File: rtl/muldiv_seq_ctrl.sv
module muldiv_seq_ctrl #(
    parameter int STEPS   = 8,
    parameter int LATENCY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic load_o,
    output logic step_o,
    output logic commit_o
);
    import muldiv_pkg::*;

    localparam int CW = $clog2(LATENCY);
    localparam logic [CW-1:0] LAST_STEP   = CW'(STEPS - 1);
    localparam logic [CW-1:0] LAST_CLOCK  = CW'(LATENCY - 1);

    seq_state_t     state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        busy_o   = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        commit_o = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o   = 1'b1;
                    cnt_nx   = '0;
                    state_nx = ST_ITERATE;
                end
            end
            ST_ITERATE: begin
                busy_o = 1'b1;
                step_o = 1'b1;
                cnt_nx = cnt + 1'b1;
                if (cnt == LAST_STEP) begin
                    state_nx = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                busy_o = 1'b1;
                if (cnt == LAST_CLOCK) begin
                    commit_o = 1'b1;
                    cnt_nx   = '0;
                    state_nx = ST_IDLE;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R8: once running, the count only advances; a new start cannot restart it
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE) || (cnt == CW'($past(cnt) + 1'b1)));

    // R7: the commit falls on the last clock of the window
    assert_commit_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (state == ST_SETTLE) && (cnt == LAST_CLOCK));

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         op_div_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_lo_o,
    output logic [W-1:0] res_hi_o
);
    import muldiv_pkg::*;

    logic [W:0]   hi;
    logic [W-1:0] lo;
    logic [W-1:0] divisor;
    muldiv_op_t   op_q;

    logic [W:0]   mul_sum;
    logic [W:0]   rem_shift;
    logic [W+1:0] rem_diff;
    logic [W:0]   hi_nx;
    logic [W-1:0] lo_nx;

    always_comb begin
        mul_sum   = {1'b0, hi[W-1:0]} + (lo[0] ? {1'b0, divisor} : '0);
        rem_shift = {hi[W-1:0], lo[W-1]};
        rem_diff  = {1'b0, rem_shift} - {2'b00, divisor};
        if (op_q == OP_MUL) begin
            hi_nx = {1'b0, mul_sum[W:1]};
            lo_nx = {mul_sum[0], lo[W-1:1]};
        end else if (!rem_diff[W+1]) begin
            hi_nx = rem_diff[W:0];
            lo_nx = {lo[W-2:0], 1'b1};
        end else begin
            hi_nx = rem_shift;
            lo_nx = {lo[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi      <= '0;
            lo      <= '0;
            divisor <= '0;
            op_q    <= OP_MUL;
        end else if (load_i) begin
            hi      <= '0;
            lo      <= a_i;
            divisor <= b_i;
            op_q    <= op_div_i ? OP_DIV : OP_MUL;
        end else if (step_i) begin
            hi <= hi_nx;
            lo <= lo_nx;
        end
    end

    // multiply: high byte / low byte; divide: remainder / quotient
    assign res_lo_o = lo;
    assign res_hi_o = hi[W-1:0];

    // R5: restoring divide keeps the partial remainder below the divisor
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && op_q == OP_DIV && divisor != '0) |=> (hi < {1'b0, divisor}));

endmodule

// File: rtl/byte_muldiv_unit.sv
module byte_muldiv_unit #(
    parameter int W          = 8,
    parameter int MC_COUNT   = 4,
    parameter int CLK_PER_MC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_div_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] b_o,
    output logic         cy_o,
    output logic         ov_o
);
    import muldiv_pkg::*;

    localparam int LATENCY = MC_COUNT * CLK_PER_MC;

    logic         load, step, commit;
    logic [W-1:0] res_lo, res_hi;
    logic [W-1:0] a_q;
    muldiv_op_t   op_q;
    logic         dz_q;

    muldiv_seq_ctrl #(.STEPS(W), .LATENCY(LATENCY)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .load_o   (load),
        .step_o   (step),
        .commit_o (commit)
    );

    muldiv_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .op_div_i (op_div_i),
        .a_i      (acc_i),
        .b_i      (b_i),
        .res_lo_o (res_lo),
        .res_hi_o (res_hi)
    );

    // operand capture for the divide-by-zero path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            op_q <= OP_MUL;
            dz_q <= 1'b0;
        end else if (load) begin
            a_q  <= acc_i;
            op_q <= op_div_i ? OP_DIV : OP_MUL;
            dz_q <= (b_i == '0);
        end
    end

    // result and flag commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o  <= '0;
            b_o    <= '0;
            cy_o   <= 1'b0;
            ov_o   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= commit;
            if (commit) begin
                cy_o <= 1'b0;
                if (op_q == OP_DIV && dz_q) begin
                    acc_o <= a_q;
                    b_o   <= '0;
                    ov_o  <= 1'b1;
                end else if (op_q == OP_DIV) begin
                    acc_o <= res_lo;
                    b_o   <= res_hi;
                    ov_o  <= 1'b0;
                end else begin
                    acc_o <= res_lo;
                    b_o   <= res_hi;
                    ov_o  <= (res_hi != '0);
                end
            end
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_carry_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cy_o);

    assert_mul_ov_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MUL) |-> (ov_o == (b_o != '0)));

    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_DIV && dz_q) |-> (ov_o && acc_o == a_q && b_o == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(acc_o) && $stable(b_o) && $stable(cy_o) && $stable(ov_o)));

endmodule

// File: tb/byte_muldiv_unit_test.sv
module byte_muldiv_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_div_i = 1'b0;
    logic [7:0] acc_i = '0;
    logic [7:0] b_i = '0;
    logic       busy_o, done_o, cy_o, ov_o;
    logic [7:0] acc_o, b_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam int LAT = 16;

    // {op, a, b, expected acc, expected b, expected ov}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'hFF, 8'hFF, 8'h01, 8'hFE, 1'b1},
        {1'b0, 8'h0F, 8'h11, 8'hFF, 8'h00, 1'b0},
        {1'b0, 8'h10, 8'h10, 8'h00, 8'h01, 1'b1},
        {1'b0, 8'h80, 8'h02, 8'h00, 8'h01, 1'b1},
        {1'b0, 8'h0C, 8'h0D, 8'h9C, 8'h00, 1'b0},
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0},
        {1'b1, 8'hFF, 8'h01, 8'hFF, 8'h00, 1'b0},
        {1'b1, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0},
        {1'b1, 8'h64, 8'h07, 8'h0E, 8'h02, 1'b0},
        {1'b1, 8'h05, 8'h09, 8'h00, 8'h05, 1'b0},
        {1'b1, 8'hFE, 8'h10, 8'h0F, 8'h0E, 1'b0},
        {1'b1, 8'h37, 8'h00, 8'h37, 8'h00, 1'b1},
        {1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1}
    };

    byte_muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
        .acc_i(acc_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launches one operation at a falling edge and waits for done; returns clocks to done
    task automatic launch(input bit op, input logic [7:0] a, input logic [7:0] b, output int waited);
        op_div_i = op; acc_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 1;
        check(busy_o === 1'b1, "R7 busy after start", busy_o, 1);
        while (done_o !== 1'b1 && waited < 40) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_and_check(input bit op, input logic [7:0] a, input logic [7:0] b,
                                 input logic [7:0] ea, input logic [7:0] eb, input bit eov);
        int waited;
        launch(op, a, b, waited);
        check(waited == LAT + 1, "R7 latency", waited, LAT + 1);
        check(busy_o === 1'b0, "R7 busy low at done", busy_o, 0);
        check(acc_o === ea, op ? "R5/R6 acc result" : "R2 acc result", acc_o, ea);
        check(b_o === eb, op ? "R5/R6 b result" : "R2 b result", b_o, eb);
        check(ov_o === eov, op ? "R5/R6 overflow" : "R3 overflow", ov_o, eov);
        check(cy_o === 1'b0, "R4 carry", cy_o, 0);
        @(negedge clk);
        check(done_o === 1'b0, "R7 done one clock", done_o, 0);
    endtask

    task automatic model(input bit op, input int a, input int b,
                         output logic [7:0] ea, output logic [7:0] eb, output bit eov);
        int p;
        if (!op) begin
            p = a * b;
            ea = p[7:0]; eb = p[15:8]; eov = (p > 255);
        end else if (b == 0) begin
            ea = a[7:0]; eb = 8'h00; eov = 1'b1;
        end else begin
            ea = 8'(a / b); eb = 8'(a % b); eov = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ea, eb;
        bit eov;
        int waited;
        logic [7:0] hold_a, hold_b;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 reset busy/done", {busy_o, done_o}, 0);
        check(acc_o === 8'h00 && b_o === 8'h00, "R1 reset results", {acc_o, b_o}, 0);
        check(cy_o === 1'b0 && ov_o === 1'b0, "R1 reset flags", {cy_o, ov_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            run_and_check(VEC[i][33], VEC[i][32:25], VEC[i][24:17],
                          VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
        end

        // operand grid for both operations against the model (R2, R3, R5, R6)
        for (int op = 0; op < 2; op++) begin
            for (int a = 0; a < 256; a += 17) begin
                for (int b = 0; b < 256; b += 17) begin
                    model(op[0], a, b, ea, eb, eov);
                    run_and_check(op[0], a[7:0], b[7:0], ea, eb, eov);
                end
            end
        end

        // R8: start while busy is ignored
        op_div_i = 1'b0; acc_i = 8'h03; b_i = 8'h05; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        op_div_i = 1'b1; acc_i = 8'hC8; b_i = 8'h07; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 6;
        while (done_o !== 1'b1 && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(waited == LAT + 1, "R8 original timing kept", waited, LAT + 1);
        check(acc_o === 8'h0F && b_o === 8'h00, "R8 first operands used", {acc_o, b_o}, 16'h0F00);
        repeat (20) begin
            @(negedge clk);
            check(done_o === 1'b0 && busy_o === 1'b0, "R8 no extra operation", {busy_o, done_o}, 0);
        end

        // R9: results hold between done pulses while inputs move
        hold_a = acc_o; hold_b = b_o;
        op_div_i = 1'b1; acc_i = 8'h00; b_i = 8'h00;
        repeat (5) @(negedge clk);
        check(acc_o === hold_a && b_o === hold_b && ov_o === 1'b0, "R9 hold while idle",
              {acc_o, b_o}, {hold_a, hold_b});
        op_div_i = 1'b1; acc_i = 8'h09; b_i = 8'h04; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < LAT - 1; k++) begin
            check(acc_o === hold_a && b_o === hold_b, "R9 hold while busy",
                  {acc_o, b_o}, {hold_a, hold_b});
            @(negedge clk);
        end
        @(negedge clk);
        check(done_o === 1'b1 && acc_o === 8'h02 && b_o === 8'h01, "R9 update at done",
              {done_o, acc_o, b_o}, {1'b1, 8'h02, 8'h01});

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule